// File: doc/BRIEF.md
# Cycle-Prescaled Interrupt Timer

This block is an up-counting interrupt timer that raises an active-high IRQ after a programmable number of ticks. The CPU sets an 8-bit reload value through two 4-bit writes, one for each half. A control write then starts the counter from that value. The counter moves up by one on every tick. When it rolls over from its maximum value to zero, it reloads the value and raises the IRQ.

Ticks come from one of two sources, and the control byte picks which one.

- **Raw-cycle mode:** each CPU-cycle enable pulse is one tick.
- **Line mode:** a signed dot prescaler drops by three on each CPU cycle. When it reaches zero or goes below zero, 341 is added back and one tick is issued. This gives a scanline rate taken from the CPU clock alone.

A separate acknowledge write clears the IRQ. It can also re-arm or stop counting, depending on an auto-restart bit held in the control byte.

Top module: `cyc_irq_timer`

## Requirements
- R1: Reset clears the reload value, the control byte, the counter, the prescaler and the IRQ. A later write of control 0x06 with no reload write gives an IRQ after exactly 256 cycle enables.
- R2: `wr_sel`=0 replaces bits 3:0 of the reload value with `wr_data[3:0]`. `wr_sel`=1 replaces bits 7:4 of the reload value with `wr_data[3:0]`. `wr_data[7:4]` has no effect on either write.
- R3: `wr_sel`=2 stores the control byte. Bit 0 is auto-restart, bit 1 is run and bit 2 selects raw-cycle mode. If bit 1 is set, the counter loads the reload value and the prescaler loads 341. The IRQ is low in the next cycle whether bit 1 is set or not.
- R4: `wr_sel`=3 copies control bit 0 into control bit 1 and clears the IRQ. The counter is not reloaded.
- R5: In raw-cycle mode, each clock with `cpu_tick` high is one tick.
- R6: In line mode, the prescaler subtracts 3 per enabled cycle. When the result is at or below 0, it adds 341 and issues a tick. From a fresh start the tick spacing is 114, 114 and 113 cycles, and this pattern repeats.
- R7: A tick increments the counter. When a tick takes the counter from 0xFF to 0x00, the counter reloads the reload value and the IRQ rises in that same clock. The period is 256 minus the reload value in ticks.
- R8: While control bit 1 is clear, neither the counter nor the prescaler moves.
- R9: A clock with `cpu_tick` low advances nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_tick | input | 1 | One-clock enable marking a CPU cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 reload low half, 1 reload high half, 2 control, 3 acknowledge |
| wr_data | input | 8 | Write data |
| irq | output | 1 | Interrupt request, active high |

## Verification
The counter and the prescaler can only be seen through when the IRQ rises. So every fault in internal state appears as an IRQ that comes early, comes late or never comes. In raw-cycle mode, a wrong counter or reload value moves the edge by a whole number of enables within one period. This is at most 256 cycles.

A prescaler fault in line mode shows up later. It needs one or two line periods of 113 to 114 cycles before the edge moves. For this reason the bench checks the cycle just before each expected rise as well as the rise itself, and it continues into a second line period.

// File: rtl/cyc_irq_timer_pkg.sv
package cyc_irq_timer_pkg;
   // control byte bit positions
   localparam int CTL_AUTO = 0;
   localparam int CTL_RUN  = 1;
   localparam int CTL_RAW  = 2;
   localparam int CTL_W    = 3;

   typedef enum logic [1:0] {
      SEL_RLD_LO = 2'd0,
      SEL_RLD_HI = 2'd1,
      SEL_CTRL   = 2'd2,
      SEL_ACK    = 2'd3
   } sel_e;
endpackage

// File: rtl/cyc_irq_timer_regs.sv
module cyc_irq_timer_regs
   import cyc_irq_timer_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [CNT_W-1:0]  reload,
   output logic [CTL_W-1:0]  ctl,
   output logic              ctl_wr,
   output logic              ack_wr,
   output logic              start
);
   localparam int HALF = CNT_W / 2;

   initial begin
      assert (CNT_W % 2 == 0) else $error("CNT_W must be even");
      assert (HALF <= DATA_W && CTL_W <= DATA_W) else $error("DATA_W too narrow");
   end

   logic lo_wr, hi_wr;

   always_comb begin
      lo_wr  = wr_en && (wr_sel == SEL_RLD_LO);
      hi_wr  = wr_en && (wr_sel == SEL_RLD_HI);
      ctl_wr = wr_en && (wr_sel == SEL_CTRL);
      ack_wr = wr_en && (wr_sel == SEL_ACK);
      start  = ctl_wr && wr_data[CTL_RUN];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reload <= '0;
         ctl    <= '0;
      end else begin
         if (lo_wr) reload[HALF-1:0]     <= wr_data[HALF-1:0];
         if (hi_wr) reload[CNT_W-1:HALF] <= wr_data[HALF-1:0];
         if (ctl_wr)
            ctl <= wr_data[CTL_W-1:0];
         else if (ack_wr)
            ctl[CTL_RUN] <= ctl[CTL_AUTO];
      end
   end

   // R4: acknowledge copies auto-restart into run
   assert_ack_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ack_wr |=> (ctl[CTL_RUN] == $past(ctl[CTL_AUTO])));

   // R2: high half of a reload write taken from data low bits
   assert_hi_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hi_wr |=> (reload[CNT_W-1:HALF] == $past(wr_data[HALF-1:0])));
endmodule

// File: rtl/cyc_irq_timer_prescale.sv
module cyc_irq_timer_prescale #(
   parameter int LINE_DOTS = 341,
   parameter int DOTS_STEP = 3,
   parameter bit LINE_MODE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv,
   input  logic raw_mode,
   input  logic start,
   output logic step
);
   localparam int PRE_W = $clog2(LINE_DOTS + 1) + 1;

   initial begin
      assert (DOTS_STEP > 0 && DOTS_STEP < LINE_DOTS) else $error("bad DOTS_STEP");
   end

   generate
      if (LINE_MODE) begin : g_line
         logic signed [PRE_W-1:0] pre_q;
         logic signed [PRE_W-1:0] pre_dec;
         logic                    line_done;

         always_comb begin
            pre_dec   = pre_q - PRE_W'(DOTS_STEP);
            line_done = pre_dec[PRE_W-1] || (pre_dec == '0);
            step      = adv && (raw_mode || line_done);
         end

         always_ff @(posedge clk) begin
            if (!rst_n)
               pre_q <= '0;
            else if (start)
               pre_q <= PRE_W'(LINE_DOTS);
            else if (adv && !raw_mode)
               pre_q <= line_done ? pre_dec + PRE_W'(LINE_DOTS) : pre_dec;
         end

         // R6: held prescaler stays within one line
         assert_pre_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (pre_q >= 0) && (pre_q <= PRE_W'(LINE_DOTS)));
         // R8: frozen while not advancing
         assert_pre_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!adv && !start) |=> $stable(pre_q));
      end else begin : g_raw
         always_comb step = adv;
      end
   endgenerate
endmodule

// File: rtl/cyc_irq_timer_count.sv
module cyc_irq_timer_count #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             start,
   input  logic             clr,
   input  logic [CNT_W-1:0] reload,
   output logic             irq
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;
   logic             wrap;

   always_comb wrap = step && (cnt_q == CNT_MAX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         irq   <= 1'b0;
      end else begin
         if (start)
            cnt_q <= reload;
         else if (step)
            cnt_q <= wrap ? reload : cnt_q + 1'b1;
         if (wrap)
            irq <= 1'b1;
         else if (clr)
            irq <= 1'b0;
      end
   end

   // R7: IRQ only rises on a rollover, which leaves the reload value behind
   assert_rise_on_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(step) && cnt_q == $past(reload)));
   // R9: counter only moves on a step or a start
   assert_cnt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !start) |=> $stable(cnt_q));
endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
   import cyc_irq_timer_pkg::*;
#(
   parameter int CNT_W     = 8,
   parameter int DATA_W    = 8,
   parameter int LINE_DOTS = 341,
   parameter int DOTS_STEP = 3,
   parameter bit LINE_MODE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_tick,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic              irq
);
   logic [CNT_W-1:0] reload;
   logic [CTL_W-1:0] ctl;
   logic             ctl_wr, ack_wr, start, adv, step;

   cyc_irq_timer_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .reload(reload), .ctl(ctl),
      .ctl_wr(ctl_wr), .ack_wr(ack_wr), .start(start)
   );

   // a control write takes the cycle; no advance beside it
   always_comb adv = ctl[CTL_RUN] && cpu_tick && !ctl_wr;

   cyc_irq_timer_prescale #(.LINE_DOTS(LINE_DOTS), .DOTS_STEP(DOTS_STEP),
                            .LINE_MODE(LINE_MODE)) u_pre (
      .clk(clk), .rst_n(rst_n), .adv(adv), .raw_mode(ctl[CTL_RAW]),
      .start(start), .step(step)
   );

   cyc_irq_timer_count #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .step(step), .start(start),
      .clr(ctl_wr || ack_wr), .reload(reload), .irq(irq)
   );

   // R3: control write leaves IRQ low next cycle
   assert_ctrl_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_CTRL) |=> !irq);
   // R8: no rise while stopped
   assert_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl[CTL_RUN]) |=> !$rose(irq));
   // R9: no rise without a CPU cycle
   assert_no_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_tick) |=> !$rose(irq));
endmodule

// File: tb/test_cyc_irq_timer.sv
module test_cyc_irq_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_sel = '0;
   logic [7:0] wr_data = '0;
   logic       irq;
   int         n_chk = 0;
   int         n_bad = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   cyc_irq_timer i_cyc_irq_timer (
      .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .irq(irq)
   );

   task automatic chk(input string req, input logic exp);
      n_chk++;
      if (irq !== exp) begin
         n_bad++;
         $display("FAIL %s: irq=%b expected %b at %0t", req, irq, exp, $time);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      cpu_tick = 1'b1;
      repeat (n) @(negedge clk);
      cpu_tick = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 irq low after reset", 1'b0);
      wr(2'd2, 8'h06);
      ticks(255); chk("R1 reload zero, 255 enables", 1'b0);
      ticks(1);   chk("R1 R7 rollover after 256", 1'b1);
   endtask

   task automatic t_raw();
      wr(2'd0, 8'h20);           // low half 0, upper data bits junk
      wr(2'd1, 8'hAF);           // high half F
      wr(2'd2, 8'h06);
      chk("R3 control write clears irq", 1'b0);
      ticks(15); chk("R2 R5 reload F0, 15 ticks", 1'b0);
      ticks(1);  chk("R5 R7 reload F0, 16 ticks", 1'b1);
      wr(2'd3, 8'hFF);           // auto bit 0 clear -> stop
      chk("R4 ack clears irq", 1'b0);
      ticks(300); chk("R8 stopped after ack", 1'b0);
      wr(2'd2, 8'h07);
      ticks(16); chk("R7 restart period 16", 1'b1);
      wr(2'd3, 8'h00);           // auto set -> keep running
      chk("R4 ack clears irq with auto", 1'b0);
      ticks(15); chk("R4 R7 keeps counting, 15", 1'b0);
      ticks(1);  chk("R4 R7 keeps counting, 16", 1'b1);
   endtask

   task automatic t_gate();
      wr(2'd2, 8'h06);
      ticks(15);
      repeat (50) @(negedge clk);
      chk("R9 idle cycles do not count", 1'b0);
      ticks(1); chk("R9 resumes on enable", 1'b1);
   endtask

   task automatic t_ctrl_stop();
      wr(2'd2, 8'h04);
      chk("R3 control without run clears irq", 1'b0);
      ticks(300); chk("R8 no run bit", 1'b0);
   endtask

   task automatic t_line();
      wr(2'd0, 8'hFE);
      wr(2'd1, 8'h0F);           // reload FE
      wr(2'd2, 8'h03);
      ticks(227); chk("R6 two lines minus one", 1'b0);
      ticks(1);   chk("R6 two lines = 228", 1'b1);
      wr(2'd3, 8'h00);
      chk("R4 ack in line mode", 1'b0);
      ticks(226); chk("R6 next pair minus one", 1'b0);
      ticks(1);   chk("R6 next pair = 227", 1'b1);
   endtask

   task automatic t_reset_mid();
      wr(2'd2, 8'h06);
      ticks(5);
      do_reset();
      chk("R1 irq low after mid reset", 1'b0);
      wr(2'd2, 8'h06);
      ticks(255); chk("R1 reload cleared by reset", 1'b0);
      ticks(1);   chk("R1 period 256 after reset", 1'b1);
   endtask

   initial begin
      t_reset();
      t_raw();
      t_gate();
      t_ctrl_stop();
      t_line();
      t_reset_mid();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run incomplete, expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule